// File: doc/BRIEF.md
# Backup Battery Check Scheduler

This block decides when a backup battery is measured and keeps the verdict. A battery comparator elsewhere on the chip reports "below threshold" only when asked. The scheduler raises a one-cycle measurement request and samples the comparator a fixed number of clock cycles later. It raises the request on every power-up, meaning every rise of the main power-good signal. While main power stays good, it raises it again after a long, fixed number of timebase ticks. The default is 86400 ticks, which is one day at a one-second tick.

A low verdict drives an active-low battery-low flag. The flag is held until a later check, either at a power-up or at a scheduled interval, finds the battery good. The comparator's value between checks is ignored. A second output tells software how serious a low verdict is:
- If the low verdict came from a power-up check, the memory held on battery is suspect.
- If it came from a periodic check, the battery is near the end of its life but no data was lost.

Nothing is measured while main power is absent. A pending measurement is dropped if power fails before its sample.

Top module: `nvb_batt_monitor`

## Requirements
- R1: While reset is high, and in the cycle after it, `meas_req_o` is 0, `batt_low_n_o` is 1 and `low_at_powerup_o` is 0.
- R2: `meas_req_o` is high for exactly one clock cycle. The first such cycle follows the first rising edge that samples `pwr_good_i` high after it was sampled low, or after reset was released.
- R3: The comparator is sampled at the SAMPLE_DELAY-th rising edge after the edge that raised the request. The flag changes at that edge only. Comparator values at any other time have no effect.
- R4: A sampled comparator value of 1 (battery below threshold) drives `batt_low_n_o` to 0.
- R5: Once low, `batt_low_n_o` stays 0 whatever the comparator does between checks. It returns to 1 only when a later check samples a comparator value of 0.
- R6: While power stays good, a periodic request is raised right after the edge that samples the INTERVAL_TICKS-th tick counted since the last check start. Ticks are counted from the power-up check onward, and no request is raised on any earlier tick.
- R7: While `pwr_good_i` is low, no request is raised and ticks are not counted. If power is lost before a pending sample, that sample is abandoned and the flag is unchanged.
- R8: Every power-up check restarts the interval count from zero, so ticks counted before a power loss do not shorten the next interval.
- R9: `low_at_powerup_o` is 1 when the latched low verdict came from a power-up check. It is 0 when the verdict came from a periodic check or when the flag is deasserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Slow timebase pulse, one cycle wide |
| pwr_good_i | input | 1 | Main power within tolerance |
| batt_low_i | input | 1 | Comparator result, 1 = battery below threshold |
| meas_req_o | output | 1 | One-cycle measurement request |
| batt_low_n_o | output | 1 | Battery-low flag, active low |
| low_at_powerup_o | output | 1 | Latched low verdict came from a power-up check |

## Verification
The assertions assume the following about the inputs:
- All inputs are synchronous to the clock.
- A power loss lasts at least one sampled edge.
- The comparator holds steady across the edge at which it is sampled.
- SAMPLE_DELAY is at least one.

The bench keeps within these assumptions by changing every input only on the falling clock edge. It uses a short interval and sample delay so that scheduled checks, power loss during a pending sample, and restarts of the interval all occur within a short run.

// File: rtl/nvb_pkg.sv
package nvb_pkg;

    typedef enum logic {
        CHK_PERIODIC = 1'b0,
        CHK_POWERUP  = 1'b1
    } chk_kind_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_WAIT = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic      valid;
        logic      low;
        chk_kind_e kind;
    } chk_result_t;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/nvb_interval_timer.sv
module nvb_interval_timer
    import nvb_pkg::*;
#(
    parameter int unsigned INTERVAL_TICKS = 86400
) (
    input  logic clk,
    input  logic rst,
    input  logic restart_i,
    input  logic run_i,
    input  logic tick_i,
    output logic expire_o
);
    localparam int unsigned W = cnt_width(INTERVAL_TICKS);
    localparam logic [W-1:0] LAST = W'(INTERVAL_TICKS - 1);

    logic [W-1:0] cnt_q;
    logic         at_last;

    assign at_last  = (cnt_q == LAST);
    assign expire_o = run_i & tick_i & ~restart_i & at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (restart_i) begin
            cnt_q <= '0;
        end else if (run_i && tick_i) begin
            cnt_q <= at_last ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/nvb_check_seq.sv
module nvb_check_seq
    import nvb_pkg::*;
#(
    parameter int unsigned SAMPLE_DELAY = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pwr_good_i,
    input  logic        expire_i,
    input  logic        batt_low_i,
    output logic        req_o,
    output logic        restart_o,
    output chk_result_t result_o
);
    localparam int unsigned DW = cnt_width(SAMPLE_DELAY + 1);
    localparam logic [DW-1:0] DLY_LAST = DW'(SAMPLE_DELAY - 1);

    seq_state_e    state_q;
    chk_kind_e     kind_q;
    logic [DW-1:0] dly_q;
    logic          pg_q;
    logic          req_q;
    logic          pu_evt;
    logic          start;
    logic          sample;

    // rising power-good, or power-good already present when reset ends
    assign pu_evt = pwr_good_i & ~pg_q;
    assign start  = pu_evt | (expire_i & (state_q == SEQ_IDLE));
    assign sample = (state_q == SEQ_WAIT) & pwr_good_i & (dly_q == DLY_LAST);

    assign restart_o = pu_evt;
    assign req_o     = req_q;

    always_comb begin
        result_o.valid = sample;
        result_o.low   = batt_low_i;
        result_o.kind  = kind_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            kind_q  <= CHK_PERIODIC;
            dly_q   <= '0;
            pg_q    <= 1'b0;
            req_q   <= 1'b0;
        end else begin
            pg_q  <= pwr_good_i;
            req_q <= start;
            unique case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        state_q <= SEQ_WAIT;
                        dly_q   <= '0;
                        kind_q  <= pu_evt ? CHK_POWERUP : CHK_PERIODIC;
                    end
                end
                SEQ_WAIT: begin
                    if (!pwr_good_i || sample) begin
                        state_q <= SEQ_IDLE;
                    end else begin
                        dly_q <= dly_q + 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/nvb_flag_latch.sv
module nvb_flag_latch
    import nvb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  chk_result_t result_i,
    output logic        low_o,
    output logic        low_pu_o
);
    logic low_q;
    logic pu_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_q <= 1'b0;
            pu_q  <= 1'b0;
        end else if (result_i.valid) begin
            low_q <= result_i.low;
            pu_q  <= result_i.low & (result_i.kind == CHK_POWERUP);
        end
    end

    assign low_o    = low_q;
    assign low_pu_o = pu_q;
endmodule

// File: rtl/nvb_batt_monitor.sv
module nvb_batt_monitor
    import nvb_pkg::*;
#(
    parameter int unsigned INTERVAL_TICKS = 86400,
    parameter int unsigned SAMPLE_DELAY   = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic pwr_good_i,
    input  logic batt_low_i,
    output logic meas_req_o,
    output logic batt_low_n_o,
    output logic low_at_powerup_o
);
    logic        restart;
    logic        expire;
    logic        flag_low;
    chk_result_t result;

    nvb_interval_timer #(.INTERVAL_TICKS(INTERVAL_TICKS)) timer_i (
        .clk       (clk),
        .rst       (rst),
        .restart_i (restart),
        .run_i     (pwr_good_i),
        .tick_i    (tick_i),
        .expire_o  (expire)
    );

    nvb_check_seq #(.SAMPLE_DELAY(SAMPLE_DELAY)) seq_i (
        .clk        (clk),
        .rst        (rst),
        .pwr_good_i (pwr_good_i),
        .expire_i   (expire),
        .batt_low_i (batt_low_i),
        .req_o      (meas_req_o),
        .restart_o  (restart),
        .result_o   (result)
    );

    nvb_flag_latch latch_i (
        .clk      (clk),
        .rst      (rst),
        .result_i (result),
        .low_o    (flag_low),
        .low_pu_o (low_at_powerup_o)
    );

    assign batt_low_n_o = ~flag_low;
endmodule

// File: rtl/nvb_batt_monitor_chk.sv
module nvb_batt_monitor_chk #(
    parameter int unsigned SAMPLE_DELAY = 4
) (
    input logic clk,
    input logic rst,
    input logic pwr_good_i,
    input logic batt_low_i,
    input logic meas_req_o,
    input logic batt_low_n_o,
    input logic low_at_powerup_o
);
    localparam int unsigned SW = $clog2(SAMPLE_DELAY + 2) + 1;

    logic          rst_q = 1'b1;
    logic [SW-1:0] since_req;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            since_req <= '1;
        end else if (meas_req_o) begin
            since_req <= SW'(1);
        end else if (since_req != '1) begin
            since_req <= since_req + 1'b1;
        end
    end

    a_r1_reset_values: assert property (@(posedge clk)
        rst |=> (!meas_req_o && batt_low_n_o && !low_at_powerup_o));

    a_r2_req_one_cycle: assert property (@(posedge clk) disable iff (rst)
        meas_req_o |=> !meas_req_o);

    a_r7_req_needs_power: assert property (@(posedge clk) disable iff (rst)
        meas_req_o |-> $past(pwr_good_i));

    a_r3_flag_moves_at_delay: assert property (@(posedge clk) disable iff (rst)
        (!rst_q && !$stable(batt_low_n_o)) |-> (since_req == SW'(SAMPLE_DELAY)));

    a_r4_fall_needs_low: assert property (@(posedge clk) disable iff (rst)
        (!rst_q && $fell(batt_low_n_o)) |-> $past(batt_low_i));

    a_r5_rise_needs_good: assert property (@(posedge clk) disable iff (rst)
        (!rst_q && $rose(batt_low_n_o)) |-> !$past(batt_low_i));

    a_r9_source_implies_low: assert property (@(posedge clk) disable iff (rst)
        low_at_powerup_o |-> !batt_low_n_o);
endmodule

bind nvb_batt_monitor nvb_batt_monitor_chk #(.SAMPLE_DELAY(SAMPLE_DELAY)) chk_i (
    .clk              (clk),
    .rst              (rst),
    .pwr_good_i       (pwr_good_i),
    .batt_low_i       (batt_low_i),
    .meas_req_o       (meas_req_o),
    .batt_low_n_o     (batt_low_n_o),
    .low_at_powerup_o (low_at_powerup_o)
);

// File: tb/nvb_batt_monitor_tb_top.sv
module nvb_batt_monitor_tb_top;
    localparam int unsigned INTERVAL = 4;
    localparam int unsigned DELAY    = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic pg = 1'b0;
    logic comp = 1'b0;
    logic req;
    logic flag_n;
    logic src_pu;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    nvb_batt_monitor #(.INTERVAL_TICKS(INTERVAL), .SAMPLE_DELAY(DELAY)) dut_i (
        .clk              (clk),
        .rst              (rst),
        .tick_i           (tick),
        .pwr_good_i       (pg),
        .batt_low_i       (comp),
        .meas_req_o       (req),
        .batt_low_n_o     (flag_n),
        .low_at_powerup_o (src_pu)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // one-cycle tick; returns at the falling edge after the edge that saw it
    task automatic pulse_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic finish_sample(input logic comp_at, input logic exp_n,
                                 input logic exp_src, input string tag);
        logic old_n;
        old_n = flag_n;
        @(negedge clk);
        chk({tag, " R2 strobe drops"}, req, 1'b0);
        @(negedge clk);
        chk({tag, " R3 flag held before sample edge"}, flag_n, old_n);
        comp = comp_at;
        @(negedge clk);
        chk({tag, " R4/R5 flag after sample"}, flag_n, exp_n);
        chk({tag, " R9 source bit"}, src_pu, exp_src);
    endtask

    task automatic powerup_check(input logic comp_before, input logic comp_at,
                                 input logic exp_n, input logic exp_src, input string tag);
        @(negedge clk);
        comp = comp_before;
        pg = 1'b1;
        @(negedge clk);
        chk({tag, " R2 power-up strobe"}, req, 1'b1);
        finish_sample(comp_at, exp_n, exp_src, tag);
    endtask

    task automatic periodic_check(input logic comp_before, input logic comp_at,
                                  input logic exp_n, input string tag);
        comp = comp_before;
        for (int i = 0; i < INTERVAL - 1; i++) begin
            pulse_tick();
            chk({tag, " R6 no strobe before interval"}, req, 1'b0);
        end
        pulse_tick();
        chk({tag, " R6 periodic strobe"}, req, 1'b1);
        finish_sample(comp_at, exp_n, 1'b0, tag);
    endtask

    task automatic power_down();
        @(negedge clk) pg = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 reset strobe", req, 1'b0);
        chk("R1 reset flag", flag_n, 1'b1);
        chk("R1 reset source", src_pu, 1'b0);
        rst = 1'b0;
        for (int i = 0; i < 3; i++) begin
            pulse_tick();
            chk("R7 no check before power", req, 1'b0);
        end
    endtask

    task automatic t_latch();
        comp = 1'b0;
        repeat (10) begin
            @(negedge clk);
            chk("R5 flag held between checks", flag_n, 1'b0);
        end
        periodic_check(1'b0, 1'b0, 1'b1, "latch-clear");
    endtask

    task automatic t_unpowered();
        power_down();
        comp = 1'b1;
        for (int i = 0; i < 2 * INTERVAL + 1; i++) begin
            pulse_tick();
            chk("R7 no check without power", req, 1'b0);
        end
        powerup_check(1'b1, 1'b1, 1'b0, 1'b1, "powerup-low");
    endtask

    task automatic t_restart();
        for (int i = 0; i < 2; i++) begin
            pulse_tick();
            chk("R8 partial interval", req, 1'b0);
        end
        power_down();
        powerup_check(1'b0, 1'b0, 1'b1, 1'b0, "R5 powerup-clear");
        periodic_check(1'b0, 1'b0, 1'b1, "R8 restart");
    endtask

    task automatic t_abort();
        for (int i = 0; i < INTERVAL - 1; i++) pulse_tick();
        comp = 1'b1;
        pulse_tick();
        chk("R7 abort: strobe", req, 1'b1);
        pg = 1'b0;
        repeat (5) begin
            @(negedge clk);
            chk("R7 abort: flag unchanged", flag_n, 1'b1);
            chk("R7 abort: no strobe", req, 1'b0);
        end
    endtask

    task automatic t_reset_latched();
        powerup_check(1'b1, 1'b1, 1'b0, 1'b1, "pre-reset");
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        chk("R1 reset clears flag", flag_n, 1'b1);
        chk("R1 reset clears source", src_pu, 1'b0);
        chk("R1 reset strobe low", req, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R2 check after reset with power", req, 1'b1);
        finish_sample(1'b1, 1'b0, 1'b1, "post-reset");
    endtask

    initial begin
        t_reset();
        powerup_check(1'b1, 1'b0, 1'b1, 1'b0, "R3 glitch ignored");
        periodic_check(1'b1, 1'b1, 1'b0, "R4 periodic-low");
        t_latch();
        t_unpowered();
        t_restart();
        t_abort();
        t_reset_latched();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule